// File: doc/BRIEF.md
# Weighted masked SAD accumulator

This block scores a motion candidate when overlapped-block prediction is in use. Each predictor pixel is multiplied by a per-position mask weight. The product is taken from a signed, pre-weighted source value, and the magnitude of that difference is rounded down by twelve bits. The rounded terms for the whole block are added into a 32-bit total. The block receives the three operand streams in raster order, eight positions per beat, and returns one unsigned 32-bit score per block.

A caller pulses `start_i` with the block width and height given as log2 codes and with the pixel depth mode. It then sends `W*H/8` beats over a valid/ready handshake. For blocks four pixels wide, each beat carries two consecutive rows of four pixels. For wider blocks, a beat carries eight consecutive pixels of one row. When the last beat has been folded into the total, `done_o` pulses for one cycle and `sum_o` presents the score. The score stays on `sum_o` until the next start is accepted. A size outside the supported set is rejected with a one-cycle error pulse and no run is started.

Top module: `wsad_accum`

## Requirements
- R1: Each lane contributes `(|wsrc - pix*msk| + 2048) >> 12`. Here `wsrc` is the lane's 32-bit field taken as two's complement, `msk` is bits [14:0] of the lane's 32-bit mask field, and the magnitude is computed without overflow. Lane `i` uses bits `[32*i+31:32*i]` of the source and mask buses and bits `[16*i+15:16*i]` of the pixel bus.
- R2: When `hbd_i` is 0 at start, the pixel is bits [7:0] of its 16-bit container and bits [15:8] have no effect. When `hbd_i` is 1, the pixel is bits [14:0] and bit 15 has no effect. Both are zero-extended.
- R3: The total starts at zero on each accepted start. It adds all eight lane terms of every accepted beat, wraps modulo 2^32, and holds its value on `sum_o` while the block is idle and no start is given.
- R4: A run accepts exactly `2^(wcode+hcode-3)` beats, which is H/2 beats for 4-wide blocks. `beat_ready_o` is 1 in the cycle after an accepted start and stays 1 until the last beat is accepted. It is 0 from the following cycle on.
- R5: If the last beat is accepted at clock edge k, `done_o` is 1 only between edges k+1 and k+2. In that cycle `sum_o` holds the final total and `busy_o` is 0.
- R6: Start is accepted only for these codes: `wcode` and `hcode` each in 2..7, differing by at most 2, and a code of 7 paired only with 6 or 7. Otherwise `err_o` is 1 for exactly the one cycle after the start edge, and `busy_o` and `done_o` stay 0.
- R7: `start_i` raised while busy has no effect. It raises no error, and it changes neither the beat count nor the total of the run in progress.
- R8: Synchronous reset `rst` clears `busy_o`, `beat_ready_o`, `done_o`, `err_o` and `sum_o` to 0 at the next edge, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a block; sampled only while idle |
| wcode_i | input | 3 | log2 of block width |
| hcode_i | input | 3 | log2 of block height |
| hbd_i | input | 1 | 1: 15-bit pixels in 16-bit containers, 0: 8-bit pixels |
| beat_valid_i | input | 1 | Beat data present |
| beat_ready_o | output | 1 | Block can take a beat |
| pix_i | input | 128 | Eight 16-bit pixel containers |
| wsrc_i | input | 256 | Eight signed 32-bit weighted-source values |
| mask_i | input | 256 | Eight 32-bit mask weights |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected size |
| sum_o | output | 32 | Running and final total |

## Verification
A beat accepted at edge k enters the total at edge k+1. The done pulse is raised at that same edge, so the bench drives every input on the falling edge. After the last beat it samples ready low and done low at the first falling edge, and done high with the expected total at the second. A size error appears at the first falling edge after the start edge and is gone at the next one. The ready level is read at each falling edge before a beat is counted as sent. That way the bench's expected total includes exactly the beats the block accepts. The expected sum is rebuilt from the lane formula in 64-bit arithmetic over every legal size in both depth modes, with idle gaps between beats.

// File: rtl/wsad_pkg.sv
package wsad_pkg;
    localparam int LANES    = 8;
    localparam int PIX_W    = 16;
    localparam int DATA_W   = 32;
    localparam int MUL_W    = 15;
    localparam int SHIFT    = 12;
    localparam int CODE_W   = 3;
    localparam int MIN_CODE = 2;
    localparam int MAX_CODE = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } wsad_state_e;
endpackage

// File: rtl/wsad_lane.sv
module wsad_lane #(
    parameter int PIX_W  = 16,
    parameter int DATA_W = 32,
    parameter int MUL_W  = 15,
    parameter int SHIFT  = 12,
    localparam int TERM_W = DATA_W + 2 - SHIFT
) (
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              hbd_i,
    input  logic [DATA_W-1:0] wsrc_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [TERM_W-1:0] term_o
);
    localparam int EXT_W = DATA_W + 2;
    localparam logic [EXT_W-1:0] BIAS =
        {{(EXT_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};

    logic [MUL_W-1:0]   pix_v;
    logic [2*MUL_W-1:0] prod;
    logic [EXT_W-1:0]   diff;
    logic [EXT_W-1:0]   mag;
    logic [EXT_W-1:0]   biased;

    always_comb begin
        pix_v  = hbd_i ? pix_i[MUL_W-1:0] : {{(MUL_W-8){1'b0}}, pix_i[7:0]};
        prod   = pix_v * mask_i[MUL_W-1:0];
        diff   = {{2{wsrc_i[DATA_W-1]}}, wsrc_i}
               - {{(EXT_W-2*MUL_W){1'b0}}, prod};
        mag    = diff[EXT_W-1] ? (~diff + 1'b1) : diff;
        biased = mag + BIAS;
        term_o = biased[EXT_W-1:SHIFT];
    end
endmodule

// File: rtl/wsad_tree.sv
module wsad_tree #(
    parameter int LANES  = 8,
    parameter int TERM_W = 22,
    localparam int SUM_W = TERM_W + $clog2(LANES)
) (
    input  logic [LANES*TERM_W-1:0] terms_i,
    output logic [SUM_W-1:0]        sum_o
);
    logic [SUM_W-1:0] node [2*LANES-1];

    for (genvar l = 0; l < LANES; l++) begin : g_leaf
        assign node[LANES-1+l] = {{(SUM_W-TERM_W){1'b0}}, terms_i[l*TERM_W +: TERM_W]};
    end
    for (genvar n = 0; n < LANES-1; n++) begin : g_node
        assign node[n] = node[2*n+1] + node[2*n+2];
    end
    assign sum_o = node[0];
endmodule

// File: rtl/wsad_size.sv
module wsad_size #(
    parameter int CODE_W    = 3,
    parameter int MIN_CODE  = 2,
    parameter int MAX_CODE  = 7,
    parameter int LANE_LOG2 = 3,
    localparam int CNT_W    = 2*MAX_CODE - LANE_LOG2 + 1
) (
    input  logic [CODE_W-1:0] wcode_i,
    input  logic [CODE_W-1:0] hcode_i,
    output logic              legal_o,
    output logic [CNT_W-1:0]  last_o
);
    logic [CODE_W:0] w_e, h_e, esum, expo;
    logic [CNT_W:0]  onehot;
    logic            in_range, close, big_ok;

    always_comb begin
        w_e      = {1'b0, wcode_i};
        h_e      = {1'b0, hcode_i};
        in_range = (int'(w_e) >= MIN_CODE) && (int'(w_e) <= MAX_CODE)
                && (int'(h_e) >= MIN_CODE) && (int'(h_e) <= MAX_CODE);
        close    = (w_e >= h_e) ? ((w_e - h_e) <= 2) : ((h_e - w_e) <= 2);
        big_ok   = !((int'(w_e) == MAX_CODE) && (int'(h_e) < MAX_CODE-1))
                && !((int'(h_e) == MAX_CODE) && (int'(w_e) < MAX_CODE-1));
        legal_o  = in_range && close && big_ok;
        esum     = w_e + h_e;
        expo     = (int'(esum) >= LANE_LOG2) ? esum - (CODE_W+1)'(LANE_LOG2) : '0;
        onehot   = (CNT_W+1)'(1) << expo;
        last_o   = onehot[CNT_W-1:0] - 1'b1;
    end
endmodule

// File: rtl/wsad_accum.sv
module wsad_accum
    import wsad_pkg::*;
#(
    parameter int LANES_P  = LANES,
    parameter int PIX_W_P  = PIX_W,
    parameter int DATA_W_P = DATA_W,
    parameter int MUL_W_P  = MUL_W,
    parameter int SHIFT_P  = SHIFT,
    parameter int CODE_W_P = CODE_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic [CODE_W_P-1:0]         wcode_i,
    input  logic [CODE_W_P-1:0]         hcode_i,
    input  logic                        hbd_i,
    input  logic                        beat_valid_i,
    output logic                        beat_ready_o,
    input  logic [LANES_P*PIX_W_P-1:0]  pix_i,
    input  logic [LANES_P*DATA_W_P-1:0] wsrc_i,
    input  logic [LANES_P*DATA_W_P-1:0] mask_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        err_o,
    output logic [DATA_W_P-1:0]         sum_o
);
    localparam int LANE_LOG2 = $clog2(LANES_P);
    localparam int TERM_W    = DATA_W_P + 2 - SHIFT_P;
    localparam int SUM_W     = TERM_W + LANE_LOG2;
    localparam int CNT_W     = 2*MAX_CODE - LANE_LOG2 + 1;

    typedef struct packed {
        wsad_state_e         st;
        logic                hbd;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    last;
        logic [SUM_W-1:0]    psum;
        logic                pv;
        logic [DATA_W_P-1:0] acc;
        logic                done;
        logic                err;
    } wsad_regs_t;

    wsad_regs_t r_q, r_d;

    logic                      legal;
    logic [CNT_W-1:0]          last_beat;
    logic [LANES_P*TERM_W-1:0] terms;
    logic [SUM_W-1:0]          beat_sum;
    logic                      take;

    wsad_size #(
        .CODE_W(CODE_W_P), .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE),
        .LANE_LOG2(LANE_LOG2)
    ) i_size (
        .wcode_i(wcode_i), .hcode_i(hcode_i),
        .legal_o(legal), .last_o(last_beat)
    );

    for (genvar l = 0; l < LANES_P; l++) begin : g_lane
        wsad_lane #(
            .PIX_W(PIX_W_P), .DATA_W(DATA_W_P), .MUL_W(MUL_W_P), .SHIFT(SHIFT_P)
        ) i_lane (
            .pix_i (pix_i [l*PIX_W_P  +: PIX_W_P]),
            .hbd_i (r_q.hbd),
            .wsrc_i(wsrc_i[l*DATA_W_P +: DATA_W_P]),
            .mask_i(mask_i[l*DATA_W_P +: DATA_W_P]),
            .term_o(terms [l*TERM_W   +: TERM_W])
        );
    end

    wsad_tree #(.LANES(LANES_P), .TERM_W(TERM_W)) i_tree (
        .terms_i(terms), .sum_o(beat_sum)
    );

    assign take = (r_q.st == ST_RUN) && beat_valid_i;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.pv   = take;
        r_d.psum = take ? beat_sum : '0;
        r_d.acc  = r_q.acc + (r_q.pv ? {{(DATA_W_P-SUM_W){1'b0}}, r_q.psum} : '0);
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (legal) begin
                        r_d.st   = ST_RUN;
                        r_d.hbd  = hbd_i;
                        r_d.cnt  = '0;
                        r_d.last = last_beat;
                        r_d.acc  = '0;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (take) begin
                    if (r_q.cnt == r_q.last) begin
                        r_d.st = ST_DRAIN;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign beat_ready_o = (r_q.st == ST_RUN);
    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
    assign sum_o        = r_q.acc;
endmodule

// File: rtl/wsad_chk.sv
module wsad_chk #(
    parameter int DATA_W_P = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic                beat_ready_o,
    input logic                busy_o,
    input logic                done_o,
    input logic                err_o,
    input logic [DATA_W_P-1:0] sum_o
);
    AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        beat_ready_o |-> busy_o); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !beat_ready_o)); // R5
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy_o)); // R5
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!busy_o && !done_o)); // R6
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> !err_o); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> !err_o); // R7
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(sum_o)); // R3
endmodule

bind wsad_accum wsad_chk #(.DATA_W_P(DATA_W_P)) i_wsad_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .beat_ready_o(beat_ready_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .sum_o(sum_o)
);

// File: tb/test_wsad_accum.sv
`timescale 1ns/1ps
module test_wsad_accum;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [2:0]   wcode_i = '0;
    logic [2:0]   hcode_i = '0;
    logic         hbd_i = 1'b0;
    logic         beat_valid_i = 1'b0;
    logic         beat_ready_o;
    logic [127:0] pix_i = '0;
    logic [255:0] wsrc_i = '0;
    logic [255:0] mask_i = '0;
    logic         busy_o, done_o, err_o;
    logic [31:0]  sum_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    wsad_accum i_wsad_accum (
        .clk(clk), .rst(rst), .start_i(start_i), .wcode_i(wcode_i), .hcode_i(hcode_i),
        .hbd_i(hbd_i), .beat_valid_i(beat_valid_i), .beat_ready_o(beat_ready_o),
        .pix_i(pix_i), .wsrc_i(wsrc_i), .mask_i(mask_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .sum_o(sum_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint lane_term(input logic [15:0] c, input logic [31:0] w,
                                         input logic [31:0] m, input bit hbd);
        longint p, d;
        p = hbd ? longint'(c[14:0]) : longint'(c[7:0]);
        d = longint'($signed(w)) - p * longint'(m[14:0]);
        if (d < 0) d = -d;
        return (d + 2048) >>> 12;
    endfunction

    function automatic bit is_legal(input int w, input int h);
        int dd;
        dd = (w > h) ? w - h : h - w;
        return (w >= 2 && w <= 7 && h >= 2 && h <= 7 && dd <= 2
                && !(w == 7 && h < 6) && !(h == 7 && w < 6));
    endfunction

    // fills one beat with random data, returns its expected contribution
    function automatic longint fill_beat(input bit hbd);
        longint s = 0;
        for (int l = 0; l < 8; l++) begin
            logic [15:0] c;
            logic [31:0] m, w;
            longint p;
            int kind;
            c = 16'($urandom);
            m = $urandom;
            kind = $urandom % 3;
            p = (hbd ? longint'(c[14:0]) : longint'(c[7:0])) * longint'(m[14:0]);
            if (kind == 0) w = $urandom;
            else if (kind == 1) w = 32'(p + longint'($urandom % 10001) - 5000);
            else w = 32'(p + (($urandom % 2) ? 2047 : -2048) + (($urandom % 2) ? 1 : 0));
            pix_i[l*16 +: 16]  = c;
            mask_i[l*32 +: 32] = m;
            wsrc_i[l*32 +: 32] = w;
            s += lane_term(c, w, m, hbd);
        end
        return s;
    endfunction

    task automatic run_block(input int w, input int h, input bit hbd, input bit inject);
        int nbeats, given;
        logic [31:0] exp_sum;
        nbeats  = 1 << (w + h - 3);
        given   = 0;
        exp_sum = '0;
        @(negedge clk);
        start_i = 1'b1; wcode_i = 3'(w); hcode_i = 3'(h); hbd_i = hbd;
        @(negedge clk);
        start_i = 1'b0; hbd_i = ~hbd;  // depth is latched at start (R2)
        check(busy_o && beat_ready_o && !err_o, "R4 run begins", beat_ready_o, 1);
        check(sum_o == 0, "R3 total cleared", sum_o, 0);
        while (given < nbeats) begin
            if (inject && given == nbeats / 2) begin
                start_i = 1'b1; wcode_i = 3'd0; hcode_i = 3'd1;
            end
            if (!beat_ready_o) begin
                check(0, "R4 ready early drop", beat_ready_o, 1);
                break;
            end
            if (($urandom % 4) == 0) begin
                beat_valid_i = 1'b0;
            end else begin
                beat_valid_i = 1'b1;
                exp_sum = exp_sum + 32'(fill_beat(hbd));
                given++;
            end
            @(negedge clk);
            if (start_i) begin
                start_i = 1'b0;
                check(!err_o && busy_o, "R7 start while busy", err_o, 0);
            end
        end
        beat_valid_i = 1'b0;
        check(!beat_ready_o, "R4 ready after last beat", beat_ready_o, 0);
        check(!done_o, "R5 done not early", done_o, 0);
        @(negedge clk);
        check(done_o && !busy_o, "R5 done pulse", done_o, 1);
        check(sum_o == exp_sum, $sformatf("R1 R3 total %0dx%0d hbd=%0d", w, h, hbd),
              sum_o, exp_sum);
        @(negedge clk);
        check(!done_o, "R5 done one cycle", done_o, 0);
        check(sum_o == exp_sum, "R3 total held", sum_o, exp_sum);
    endtask

    task automatic reject(input int w, input int h);
        @(negedge clk);
        start_i = 1'b1; wcode_i = 3'(w); hcode_i = 3'(h);
        @(negedge clk);
        start_i = 1'b0;
        check(err_o && !busy_o && !done_o, $sformatf("R6 reject %0d/%0d", w, h), err_o, 1);
        @(negedge clk);
        check(!err_o && !busy_o, "R6 error one cycle", err_o, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy_o && !beat_ready_o && !done_o && !err_o && sum_o == 0,
              "R8 reset state", sum_o, 0);
        // reset in the middle of a run
        @(negedge clk);
        start_i = 1'b1; wcode_i = 3'd3; hcode_i = 3'd3; hbd_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; beat_valid_i = 1'b1;
        void'(fill_beat(1'b0));
        repeat (3) @(negedge clk);
        beat_valid_i = 1'b0;
        check(sum_o != 0 || busy_o, "R8 run in progress", busy_o, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy_o && !beat_ready_o && !done_o && sum_o == 0, "R8 mid-run reset", sum_o, 0);
        // size sweep over every code pair, both depth modes
        for (int w = 0; w < 8; w++) begin
            for (int h = 0; h < 8; h++) begin
                if (is_legal(w, h)) begin
                    run_block(w, h, 1'b0, (w == 3 && h == 3) || (w == 2 && h == 4));
                    run_block(w, h, 1'b1, (w == 6 && h == 4));
                end else begin
                    reject(w, h);
                end
            end
        end
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule